// File: doc/BRIEF.md
# Decoder Error Recovery Sequencer

This block holds the error and event status for a variable-length bitstream decoder. It also runs the controlled shutdown that follows any decoding error. Each event input sets its own sticky status bit. The error bits are ORed into one aggregate error line. Once that line is high, a four-state sequencer carries the shutdown through in a fixed order:

1. It waits until the bus transactions already in flight have drained.
2. It asks the output DMA engine to write its buffered data to memory.
3. It raises a ready-for-reset signal and holds it until the CPU issues a software reset.

A small register port lets the CPU do three things:

- read the status, with write-one-to-clear on its bits;
- program a per-source interrupt enable mask;
- choose which stop reason produces a flush command toward the decoder front end.

The interrupt output is a level. It is the OR of every interrupt source ANDed with its enable bit. The ready-for-reset state counts as one of those sources. The decoder datapath, the DMA engines and memory are outside the block. They reach it only through the event inputs and the drain and flush handshakes.

Top module: `dec_err_recovery`

## Requirements
- R1: The status bits are: start-code-seen at bit 0, bitstream error at bit 1, run-length overflow at bit 2, motion-compensation error at bit 3 and input-DMA-done at bit 4. Each is set by its own event and stays set until the CPU writes 1 to that bit at address 0, or until a software reset.
- R2: An unexpected start code (`ev_bad_sync`) sets both bit 0 and bit 1 in the same cycle.
- R3: A last-macroblock-data strobe (`ev_mb_last`) sets bit 2 when `rl_code` is not all ones. With `rl_code` equal to all ones (0xFF) it sets no bit.
- R4: `err_any` is the OR of status bits 1 to 3. Bits 0 and 4 alone neither raise it nor start recovery.
- R5: From idle, `bus_quiesce` rises one cycle after `err_any` rises. It then stays high, with no flush request, for as long as `pend_zero` is low.
- R6: The first cycle after `pend_zero` is seen high during draining, `dma_flush_req` is high. It stays high until `flush_done` is seen, and `ready_to_reset` stays low during that time.
- R7: `ready_to_reset` rises the cycle after `flush_done` and holds until `sw_reset`. A software reset returns the sequencer to idle and clears all status bits in the next cycle.
- R8: `irq` is the OR over the sources {ready_to_reset at bit 5, status bits 4..0}, each ANDed with the same bit of the enable register at address 1.
- R9: One cycle after a rising edge of `dec_stopped`, `flush_cmd` pulses for exactly one cycle in two cases. With control bit 0 (address 2) at 1, it pulses when status bit 4 is set. With control bit 0 at 0, it pulses when status bit 0 is set. In every other case it stays low.
- R10: A status set in the same cycle as a write-one-to-clear of that bit leaves the bit set. A software reset in the same cycle as an event leaves the bit clear.
- R11: Reads return the following. Address 0 gives {ready_to_reset, status} in bits 5..0. Address 1 gives the enable register and address 2 the control register, each as written. Address 3 reads zero. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_reset | input | 1 | CPU software reset: clears status and returns the sequencer to idle |
| ev_bad_sync | input | 1 | Unexpected start code event |
| ev_bs_err | input | 1 | Generic bitstream error event |
| ev_mb_last | input | 1 | Last data of a macroblock being emitted |
| rl_code | input | RLW (8) | Run-length code sampled with `ev_mb_last` |
| ev_mc_err | input | 1 | Motion-compensation error event |
| ev_in_done | input | 1 | Input DMA done event |
| dec_stopped | input | 1 | Decoder has halted after interrupting |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (2) | Register address |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data (combinational) |
| pend_zero | input | 1 | No bus or DMA transaction in flight |
| flush_done | input | 1 | Output DMA flush finished |
| err_any | output | 1 | Aggregate error |
| bus_quiesce | output | 1 | Recovery active: start no new transactions |
| dma_flush_req | output | 1 | Request to flush output DMA buffers |
| ready_to_reset | output | 1 | Shutdown finished, waiting for software reset |
| flush_cmd | output | 1 | One-cycle flush command |
| irq | output | 1 | Level interrupt |

## Verification
A status event and a CPU write-one-to-clear can hit the same status bit in the same cycle. A software reset can likewise coincide with an event. The bench drives both pairs on one clock edge and then reads address 0. The bit must stay set in the first case and be clear in the second. The recovery walk is swept over every error kind, drain delays of 0 to 3 cycles and flush delays of 0 to 3 cycles, with a varied enable mask in each run. The expected interrupt level is computed from that mask.

// File: rtl/dec_err_pkg.sv
// Shared definitions for the decoder error recovery sequencer.
// Assumes a five-bit status vector with a fixed bit order that software decodes.
package dec_err_pkg;
    localparam int ST_W   = 5;
    localparam int SRC_W  = ST_W + 1;
    localparam int SB_SCD = 0;
    localparam int SB_BSE = 1;
    localparam int SB_RLO = 2;
    localparam int SB_MCE = 3;
    localparam int SB_IDD = 4;
    localparam logic [ST_W-1:0] ERR_MASK = 5'b01110;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_FLUSH = 2'd2,
        RS_READY = 2'd3
    } rstate_e;
endpackage

// File: rtl/err_status_reg.sv
// Sticky status register: turns event strobes into set bits, clears them by
// write-one-to-clear or software reset. Set has priority over clear.
// Assumes events are single-cycle strobes synchronous to clk.
module err_status_reg
    import dec_err_pkg::*;
#(
    parameter int RLW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_reset,
    input  logic            ev_bad_sync,
    input  logic            ev_bs_err,
    input  logic            ev_mb_last,
    input  logic [RLW-1:0]  rl_code,
    input  logic            ev_mc_err,
    input  logic            ev_in_done,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_mask,
    output logic [ST_W-1:0] status
);
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] clr_vec;

    // Map event strobes onto status bit positions.
    always_comb begin
        set_vec         = '0;
        set_vec[SB_SCD] = ev_bad_sync;
        set_vec[SB_BSE] = ev_bad_sync | ev_bs_err;
        set_vec[SB_RLO] = ev_mb_last && (rl_code != {RLW{1'b1}});
        set_vec[SB_MCE] = ev_mc_err;
        set_vec[SB_IDD] = ev_in_done;
        clr_vec         = clr_we ? clr_mask : '0;
    end

    // Hold sticky bits; set beats clear, resets beat both.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_reset && !clr_we) |=> ((status & $past(status)) == $past(status)));
    // R2
    bad_sync_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bad_sync && !sw_reset) |=> (status[SB_SCD] && status[SB_BSE]));
    // R3
    rl_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mb_last && (rl_code != {RLW{1'b1}}) && !sw_reset) |=> status[SB_RLO]);
endmodule

// File: rtl/recov_fsm.sv
// Recovery sequencer: idle -> drain in-flight transactions -> flush output
// DMA -> wait for software reset. Assumes pend_zero and flush_done are level
// or pulse indications from the bus and DMA side; software reset wins always.
module recov_fsm
    import dec_err_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sw_reset,
    input  logic    err_any,
    input  logic    pend_zero,
    input  logic    flush_done,
    output rstate_e state,
    output logic    bus_quiesce,
    output logic    dma_flush_req,
    output logic    rdy_rst
);
    rstate_e nxt;

    // Next-state selection for the shutdown order.
    always_comb begin
        nxt = state;
        case (state)
            RS_IDLE:  if (err_any)    nxt = RS_DRAIN;
            RS_DRAIN: if (pend_zero)  nxt = RS_FLUSH;
            RS_FLUSH: if (flush_done) nxt = RS_READY;
            RS_READY: nxt = RS_READY;
            default:  nxt = RS_IDLE;
        endcase
    end

    // State register with reset and software-reset return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            state <= RS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Decode handshake outputs from the state.
    always_comb begin
        bus_quiesce   = (state != RS_IDLE);
        dma_flush_req = (state == RS_FLUSH);
        rdy_rst       = (state == RS_READY);
    end

    // R5
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_DRAIN && !pend_zero && !sw_reset) |=> (state == RS_DRAIN));
    // R6
    ready_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_rst) |-> ($past(dma_flush_req) && $past(flush_done)));
    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_rst && !sw_reset) |=> rdy_rst);
endmodule

// File: rtl/flush_trigger.sv
// Flush command generator: on a rising edge of the decoder-stopped input it
// emits a one-cycle pulse if the selected stop reason is recorded in status.
// Assumes mode_in_done selects input-DMA-done (1) or start-code-seen (0).
module flush_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_in_done,
    input  logic stopped,
    input  logic scd_bit,
    input  logic idd_bit,
    output logic flush_cmd
);
    logic stopped_q;
    logic reason_ok;

    // Pick the stop reason that qualifies a flush.
    always_comb begin
        reason_ok = mode_in_done ? idd_bit : scd_bit;
    end

    // Edge-detect the stop input and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped_q <= 1'b0;
            flush_cmd <= 1'b0;
        end else begin
            stopped_q <= stopped;
            flush_cmd <= stopped && !stopped_q && reason_ok;
        end
    end

    // R9
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd |=> !flush_cmd);
    // R9
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_cmd |-> $past(stopped));
endmodule

// File: rtl/dec_err_recovery.sv
// Top of the decoder error recovery sequencer: status register, recovery
// state machine, flush trigger, CPU register port and level interrupt.
// Assumes DW >= 6 so the status plus ready bit fits one read word.
module dec_err_recovery
    import dec_err_pkg::*;
#(
    parameter int RLW = 8,
    parameter int AW  = 2,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_reset,
    input  logic           ev_bad_sync,
    input  logic           ev_bs_err,
    input  logic           ev_mb_last,
    input  logic [RLW-1:0] rl_code,
    input  logic           ev_mc_err,
    input  logic           ev_in_done,
    input  logic           dec_stopped,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           pend_zero,
    input  logic           flush_done,
    output logic           err_any,
    output logic           bus_quiesce,
    output logic           dma_flush_req,
    output logic           ready_to_reset,
    output logic           flush_cmd,
    output logic           irq
);
    localparam logic [AW-1:0] A_STAT = AW'(0);
    localparam logic [AW-1:0] A_IEN  = AW'(1);
    localparam logic [AW-1:0] A_CTL  = AW'(2);

    logic [ST_W-1:0]  status;
    logic [DW-1:0]    ien_q;
    logic [DW-1:0]    ctl_q;
    logic [SRC_W-1:0] src;
    rstate_e          state;
    logic             clr_we;

    assign clr_we = reg_we && (reg_addr == A_STAT);

    err_status_reg #(.RLW(RLW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .ev_bad_sync(ev_bad_sync),
        .ev_bs_err  (ev_bs_err),
        .ev_mb_last (ev_mb_last),
        .rl_code    (rl_code),
        .ev_mc_err  (ev_mc_err),
        .ev_in_done (ev_in_done),
        .clr_we     (clr_we),
        .clr_mask   (reg_wdata[ST_W-1:0]),
        .status     (status)
    );

    recov_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .err_any      (err_any),
        .pend_zero    (pend_zero),
        .flush_done   (flush_done),
        .state        (state),
        .bus_quiesce  (bus_quiesce),
        .dma_flush_req(dma_flush_req),
        .rdy_rst      (ready_to_reset)
    );

    flush_trigger u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_in_done(ctl_q[0]),
        .stopped     (dec_stopped),
        .scd_bit     (status[SB_SCD]),
        .idd_bit     (status[SB_IDD]),
        .flush_cmd   (flush_cmd)
    );

    // Aggregate error, interrupt sources and level interrupt.
    always_comb begin
        err_any = |(status & ERR_MASK);
        src     = {ready_to_reset, status};
        irq     = |(src & ien_q[SRC_W-1:0]);
    end

    // Enable and control registers written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            ctl_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_IEN) ien_q <= reg_wdata;
            if (reg_addr == A_CTL) ctl_q <= reg_wdata;
        end
    end

    // Read mux for the register port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STAT:  reg_rdata[SRC_W-1:0] = src;
            A_IEN:   reg_rdata = ien_q;
            A_CTL:   reg_rdata = ctl_q;
            default: reg_rdata = '0;
        endcase
    end

    // R5
    quiesce_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && !bus_quiesce && !sw_reset) |=> bus_quiesce);
    // R7
    sw_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!bus_quiesce && !err_any));
    // R6
    flush_needs_quiesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_flush_req) |-> $past(bus_quiesce));
endmodule

// File: tb/tb_dec_err_recovery.sv
`timescale 1ns/1ps
module tb_dec_err_recovery;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       ev_bad_sync = 1'b0, ev_bs_err = 1'b0, ev_mb_last = 1'b0;
    logic [7:0] rl_code = 8'h00;
    logic       ev_mc_err = 1'b0, ev_in_done = 1'b0, dec_stopped = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pend_zero = 1'b0, flush_done = 1'b0;
    logic       err_any, bus_quiesce, dma_flush_req, ready_to_reset, flush_cmd, irq;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dec_err_recovery dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .ev_bad_sync(ev_bad_sync), .ev_bs_err(ev_bs_err), .ev_mb_last(ev_mb_last),
        .rl_code(rl_code), .ev_mc_err(ev_mc_err), .ev_in_done(ev_in_done),
        .dec_stopped(dec_stopped), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_zero(pend_zero),
        .flush_done(flush_done), .err_any(err_any), .bus_quiesce(bus_quiesce),
        .dma_flush_req(dma_flush_req), .ready_to_reset(ready_to_reset),
        .flush_cmd(flush_cmd), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic do_swrst();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
    endtask

    task automatic recover(input int kind, input int dd, input int fd);
        int ie;
        int exp_st;
        int v;
        ie = (kind * 16 + dd * 4 + fd + 1) & 63;
        wr(2'd1, 8'(ie));
        pend_zero = 1'b0;
        case (kind)
            0: begin ev_bad_sync = 1'b1; exp_st = 3; end
            1: begin ev_bs_err = 1'b1;   exp_st = 2; end
            2: begin ev_mb_last = 1'b1; rl_code = 8'(dd * 60); exp_st = 4; end
            default: begin ev_mc_err = 1'b1; exp_st = 8; end
        endcase
        @(negedge clk);
        ev_bad_sync = 1'b0; ev_bs_err = 1'b0; ev_mb_last = 1'b0; ev_mc_err = 1'b0;
        rd(2'd0, v);
        chk("R1 status after event", v, exp_st);
        chk("R4 err_any", int'(err_any), 1);
        chk("R5 quiesce not yet", int'(bus_quiesce), 0);
        @(negedge clk);
        chk("R5 quiesce up", int'(bus_quiesce), 1);
        for (int i = 0; i < dd; i++) begin
            @(negedge clk);
            chk("R5 drain hold", int'(bus_quiesce && !dma_flush_req), 1);
        end
        pend_zero = 1'b1;
        @(negedge clk);
        pend_zero = 1'b0;
        chk("R6 flush req", int'(dma_flush_req), 1);
        for (int i = 0; i < fd; i++) begin
            @(negedge clk);
            chk("R6 flush hold, not ready", int'(dma_flush_req && !ready_to_reset), 1);
        end
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
        chk("R7 ready up", int'(ready_to_reset && !dma_flush_req), 1);
        repeat (2) @(negedge clk);
        chk("R7 ready held", int'(ready_to_reset), 1);
        chk("R8 irq level", int'(irq), int'(((32 | exp_st) & ie) != 0));
        do_swrst();
        rd(2'd0, v);
        chk("R7 sw reset clears", v + int'(bus_quiesce), 0);
    endtask

    initial begin
        int v;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values and unmapped address
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R11 reset value", v, 0);
        end
        chk("R11 outputs idle", int'({err_any, bus_quiesce, dma_flush_req,
                                      ready_to_reset, flush_cmd, irq}), 0);
        wr(2'd1, 8'hA5); wr(2'd2, 8'h5A); wr(2'd3, 8'hFF);
        rd(2'd1, v); chk("R11 ien readback", v, 8'hA5);
        rd(2'd2, v); chk("R11 ctl readback", v, 8'h5A);
        rd(2'd3, v); chk("R11 addr3 zero", v, 0);
        wr(2'd2, 8'h00);

        // R3 sweep of every run-length code
        for (int rl = 0; rl < 256; rl++) begin
            ev_mb_last = 1'b1; rl_code = 8'(rl);
            @(negedge clk);
            ev_mb_last = 1'b0;
            rd(2'd0, v);
            chk("R3 overflow bit", v, (rl != 255) ? 4 : 0);
            do_swrst();
        end

        // R4 non-error bits do not start recovery; R1 W1C behaviour
        ev_in_done = 1'b1;
        @(negedge clk);
        ev_in_done = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 idd not error", int'(err_any || bus_quiesce), 0);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R1 other-bit W1C keeps bit", v, 16);
        wr(2'd0, 8'h10);
        rd(2'd0, v); chk("R1 W1C clears bit", v, 0);

        // R10 same-cycle collisions
        ev_in_done = 1'b1;
        wr(2'd0, 8'h10);
        ev_in_done = 1'b0;
        rd(2'd0, v); chk("R10 set beats W1C", v, 16);
        ev_in_done = 1'b1; sw_reset = 1'b1;
        @(negedge clk);
        ev_in_done = 1'b0; sw_reset = 1'b0;
        rd(2'd0, v); chk("R10 sw reset beats set", v, 0);

        // R9 flush command over mode x reason bits
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                wr(2'd2, 8'(m));
                ev_bad_sync = s[0]; ev_in_done = s[1];
                @(negedge clk);
                ev_bad_sync = 1'b0; ev_in_done = 1'b0;
                dec_stopped = 1'b1;
                @(negedge clk);
                chk("R9 flush pulse", int'(flush_cmd), (m == 1) ? s[1] : s[0]);
                @(negedge clk);
                chk("R9 single cycle", int'(flush_cmd), 0);
                dec_stopped = 1'b0;
                do_swrst();
            end
        end
        wr(2'd2, 8'h00);

        // R5..R8 full recovery sweep
        for (int k = 0; k < 4; k++)
            for (int dd = 0; dd < 4; dd++)
                for (int fd = 0; fd < 4; fd++)
                    recover(k, dd, fd);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule